// File: doc/BRIEF.md
# Gate Driver Short-Fault Retry Controller

This block watches over one external power-switch driver. A comparator outside the block raises `vds_over` while the switch's drain-source voltage is above a programmed limit. The controller counts how long that indication lasts in microsecond ticks. If it lasts longer than a selectable fault time, the controller declares a short. A declared short removes `gate_en`. The output stage combines `gate_en` with the commanded state using a logical AND.

After a declaration, the controller follows one of two policies. In the first, it latches the driver off until the command input rises again. In the second, it waits an inhibit period of one hundred fault times, which gives a 1% retry duty, and then restores the driver. A retry is abandoned if the driver is commanded off during the inhibit period. A sticky fault flag records every declaration. Three small configuration registers are loaded through a one-cycle write strobe: the threshold code (stored and passed out), the fault-time code and the retry policy.

Top module: `gd_short_guard`

## Requirements
- R1: The fault-time register (address 1) resets to code 3. Codes 0 to 5 select a fault time of 30·2^code ticks (30, 60, 120, 240, 480, 960). The value written appears on `timer_sel` the cycle after the write.
- R2: A write of code 6 or 7 to the threshold or fault-time register leaves that register unchanged. Every write, to any address, raises `wr_ack` for exactly the cycle after the strobe, and `wr_ack` is low otherwise.
- R3: The threshold register (address 0) resets to code 3 and is presented unchanged on `thresh_sel`.
- R4: While `gate_en` and `cmd_on` are high, a short is declared on the tick after `vds_over` has been seen high on fault-time consecutive ticks. `gate_en` falls on the clock edge of the declaring tick. Any cycle with `vds_over` low restarts the count.
- R5: The detection count advances only in cycles where `tick_us` is high. Without ticks, no short is declared however long `vds_over` stays high.
- R6: With the retry policy on (address 2, bit 0 = 1; reset value 0), `gate_en` stays low for exactly 100 × fault-time ticks after a declaration. It then returns high, provided `cmd_on` stayed high throughout.
- R7: If the overload is still present after a retry, a new declaration occurs one fault time later and is followed by another full inhibit period.
- R8: If `cmd_on` is low in any cycle of the inhibit period, the retry is cancelled. `gate_en` then stays low after the period ends, until the next rising edge of `cmd_on`.
- R9: With the retry policy off, `gate_en` stays low after a declaration. It returns high on the cycle after a rising edge of `cmd_on`.
- R10: `fault_flag` is set on the cycle after a declaration and held until `clr_fault` is strobed. A declaration in the same cycle as a clear wins.
- R11: After reset, `gate_en` is high, and `fault_flag` and `wr_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle time base pulse, nominally 1 µs |
| vds_over | input | 1 | Comparator: drain-source voltage above threshold |
| cmd_on | input | 1 | Commanded driver state, high = on |
| clr_fault | input | 1 | Strobe that clears the fault flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 threshold, 1 fault time, 2 retry policy, 3 unused |
| wr_data | input | 3 | Write data; the retry policy uses bit 0 |
| wr_ack | output | 1 | Write acknowledge, one cycle after the strobe |
| thresh_sel | output | 3 | Stored threshold code for the external DAC |
| timer_sel | output | 3 | Stored fault-time code |
| gate_en | output | 1 | Driver permission, ANDed with the command downstream |
| fault_flag | output | 1 | Sticky short-fault indication |

## Verification
The embedded properties assume that every input is synchronous to `clk` and that `tick_us` is an enable sampled on the same edge as the other inputs. They also assume that a write strobe and its address and data are valid together within one cycle. The stimulus changes every input half a period away from the active edge. It holds `tick_us` high except in the window that tests tick gating, so the timing windows can be counted in whole cycles. The bench lowers `vds_over` right after each declaration, except in the case that checks a short persisting through a retry. It also issues the command toggles for cancellation and restart only while no overload is present.

// File: rtl/gsg_pkg.sv
package gsg_pkg;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_RESET = 3'b011;
    localparam logic [SEL_W-1:0] SEL_LAST_VALID = 3'b101;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOCK = 2'd2
    } gsg_state_e;

    typedef enum logic [1:0] {
        RA_THRESH = 2'd0,
        RA_TIMER  = 2'd1,
        RA_MODE   = 2'd2,
        RA_SPARE  = 2'd3
    } gsg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] thresh;
        logic [SEL_W-1:0] timer;
        logic             retry;
    } gsg_cfg_t;

    function automatic logic sel_valid(input logic [SEL_W-1:0] code);
        return code <= SEL_LAST_VALID;
    endfunction

    function automatic int unsigned fault_ticks(input int unsigned base,
                                                input logic [SEL_W-1:0] code);
        return base << code;
    endfunction

endpackage

// File: rtl/gsg_regs.sv
module gsg_regs
    import gsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [SEL_W-1:0] wr_data,
    output gsg_cfg_t         cfg,
    output logic             wr_ack
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '{thresh: SEL_RESET, timer: SEL_RESET, retry: 1'b0};
            wr_ack <= 1'b0;
        end else begin
            wr_ack <= wr_en;
            if (wr_en) begin
                case (gsg_addr_e'(wr_addr))
                    RA_THRESH: if (sel_valid(wr_data)) cfg.thresh <= wr_data;
                    RA_TIMER:  if (sel_valid(wr_data)) cfg.timer  <= wr_data;
                    RA_MODE:   cfg.retry <= wr_data[0];
                    default:   ;
                endcase
            end
        end
    end

    a_r2_ack_follows: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wr_ack);
    a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_ack);
    a_r2_reserved_timer: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data > SEL_LAST_VALID) |=> $stable(cfg.timer));
    a_r2_reserved_thresh: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0 && wr_data > SEL_LAST_VALID) |=> $stable(cfg.thresh));

endmodule

// File: rtl/gsg_detect.sv
module gsg_detect #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             watch,
    input  logic             over,
    input  logic [CNT_W-1:0] limit,
    output logic             declare
);

    logic [CNT_W-1:0] run_cnt;
    logic             at_limit;

    assign at_limit = (run_cnt >= limit);
    assign declare  = watch && over && tick && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !watch || !over) begin
            run_cnt <= '0;
        end else if (tick && !at_limit) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    a_r4_count_restart: assert property (@(posedge clk) disable iff (rst)
        !over |=> (run_cnt == '0));
    a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (watch && over && !tick) |=> $stable(run_cnt));

endmodule

// File: rtl/gsg_retry.sv
module gsg_retry
    import gsg_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             declare,
    input  logic             retry_en,
    input  logic             cmd_on,
    input  logic             clr_fault,
    input  logic [CNT_W-1:0] inh_lim,
    output logic             watch,
    output logic             gate_en,
    output logic             fault_flag
);

    gsg_state_e       state;
    logic [CNT_W-1:0] inh_cnt;
    logic             armed;
    logic             cmd_q;
    logic             on_edge;
    logic             inh_done;

    assign on_edge  = cmd_on && !cmd_q;
    assign inh_done = tick && (inh_cnt >= inh_lim - CNT_W'(1));
    assign gate_en  = (state == ST_RUN);
    assign watch    = gate_en && cmd_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            inh_cnt    <= '0;
            armed      <= 1'b0;
            cmd_q      <= 1'b0;
            fault_flag <= 1'b0;
        end else begin
            cmd_q <= cmd_on;
            if (declare)        fault_flag <= 1'b1;
            else if (clr_fault) fault_flag <= 1'b0;

            case (state)
                ST_RUN: begin
                    if (declare) begin
                        state   <= retry_en ? ST_HOLD : ST_LOCK;
                        inh_cnt <= '0;
                        armed   <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!cmd_on) armed <= 1'b0;
                    if (inh_done) begin
                        state <= (armed && cmd_on) ? ST_RUN : ST_LOCK;
                    end else if (tick) begin
                        inh_cnt <= inh_cnt + CNT_W'(1);
                    end
                end
                ST_LOCK: begin
                    if (on_edge) state <= ST_RUN;
                end
                default: state <= ST_LOCK;
            endcase
        end
    end

    a_r4_forced_off: assert property (@(posedge clk) disable iff (rst)
        declare |=> !gate_en);
    a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
        declare |=> fault_flag);
    a_r9_stays_latched: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && !on_edge) |=> !gate_en);
    a_r8_cancel_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !cmd_on) |=> !gate_en);

endmodule

// File: rtl/gd_short_guard.sv
module gd_short_guard
    import gsg_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 30,
    parameter int unsigned RETRY_MULT = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       vds_over,
    input  logic       cmd_on,
    input  logic       clr_fault,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [2:0] wr_data,
    output logic       wr_ack,
    output logic [2:0] thresh_sel,
    output logic [2:0] timer_sel,
    output logic       gate_en,
    output logic       fault_flag
);

    localparam int unsigned MAX_FAULT = BASE_TICKS << ((1 << SEL_W) - 1);
    localparam int unsigned MAX_INH   = MAX_FAULT * RETRY_MULT;
    localparam int          CNT_W     = $clog2(MAX_INH + 1);

    gsg_cfg_t         cfg;
    logic [CNT_W-1:0] fault_lim;
    logic [CNT_W-1:0] inh_lim;
    logic             declare;
    logic             watch;

    assign fault_lim  = CNT_W'(fault_ticks(BASE_TICKS, cfg.timer));
    assign inh_lim    = CNT_W'(RETRY_MULT * fault_ticks(BASE_TICKS, cfg.timer));
    assign thresh_sel = cfg.thresh;
    assign timer_sel  = cfg.timer;

    gsg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .wr_ack  (wr_ack)
    );

    gsg_detect #(.CNT_W(CNT_W)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_us),
        .watch   (watch),
        .over    (vds_over),
        .limit   (fault_lim),
        .declare (declare)
    );

    gsg_retry #(.CNT_W(CNT_W)) u_retry (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_us),
        .declare    (declare),
        .retry_en   (cfg.retry),
        .cmd_on     (cmd_on),
        .clr_fault  (clr_fault),
        .inh_lim    (inh_lim),
        .watch      (watch),
        .gate_en    (gate_en),
        .fault_flag (fault_flag)
    );

endmodule

// File: tb/gd_short_guard_test.sv
module gd_short_guard_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b0;
    logic       vds_over = 1'b0;
    logic       cmd_on = 1'b0;
    logic       clr_fault = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [2:0] wr_data = 3'd0;
    logic       wr_ack;
    logic [2:0] thresh_sel;
    logic [2:0] timer_sel;
    logic       gate_en;
    logic       fault_flag;

    gd_short_guard uut (
        .clk        (clk),
        .rst        (rst),
        .tick_us    (tick_us),
        .vds_over   (vds_over),
        .cmd_on     (cmd_on),
        .clr_fault  (clr_fault),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ack     (wr_ack),
        .thresh_sel (thresh_sel),
        .timer_sel  (timer_sel),
        .gate_en    (gate_en),
        .fault_flag (fault_flag)
    );

    always #10 clk = ~clk;

    localparam int SIG_GATE = 0, SIG_FLAG = 1, SIG_THR = 2, SIG_TMR = 3, SIG_ACK = 4;

    typedef struct {
        int    cyc;
        int    sig;
        int    val;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int probe(input int s);
        case (s)
            SIG_GATE: return int'(gate_en);
            SIG_FLAG: return int'(fault_flag);
            SIG_THR:  return int'(thresh_sel);
            SIG_TMR:  return int'(timer_sel);
            default:  return int'(wr_ack);
        endcase
    endfunction

    task automatic expect_in(input int d, input int s, input int v, input string tag);
        exp_t it;
        int   pos;
        it.cyc = cyc + d;
        it.sig = s;
        it.val = v;
        it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].cyc > it.cyc) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, it);
    endtask

    // monitor: pops every item due this cycle and compares
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t it;
            int   got;
            it = sb.pop_front();
            got = probe(it.sig);
            compared++;
            if (it.cyc != cyc || got != it.val) begin
                mismatched++;
                $display("FAIL %s: signal %0d at cycle %0d actual %0d expected %0d",
                         it.tag, it.sig, cyc, got, it.val);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [2:0] d,
                             input int s, input int v, input string tag);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        expect_in(1, SIG_ACK, 1, "R2 ack");
        if (s >= 0) expect_in(1, s, v, tag);
        step(1);
        wr_en = 1'b0;
        expect_in(1, SIG_ACK, 0, "R2 ack low");
        step(1);
    endtask

    initial begin
        step(1);
        expect_in(1, SIG_GATE, 1, "R11 reset gate");
        expect_in(1, SIG_FLAG, 0, "R11 reset flag");
        expect_in(1, SIG_ACK, 0, "R11 reset ack");
        expect_in(1, SIG_THR, 3, "R3 reset threshold");
        expect_in(1, SIG_TMR, 3, "R1 reset timer");
        step(2);
        rst = 1'b0;
        tick_us = 1'b1;
        step(1);

        // registers
        reg_write(2'd1, 3'd0, SIG_TMR, 0, "R1 timer code 0");
        reg_write(2'd0, 3'd5, SIG_THR, 5, "R3 threshold code 5");
        reg_write(2'd0, 3'd6, SIG_THR, 5, "R2 reserved threshold 6");
        reg_write(2'd1, 3'd7, SIG_TMR, 0, "R2 reserved timer 7");
        reg_write(2'd3, 3'd1, SIG_THR, 5, "R2 spare address");

        // R5: no ticks, no declaration
        cmd_on = 1'b1;
        step(1);
        tick_us  = 1'b0;
        vds_over = 1'b1;
        expect_in(80, SIG_GATE, 1, "R5 no tick");
        expect_in(80, SIG_FLAG, 0, "R5 no tick flag");
        step(80);
        vds_over = 1'b0;
        tick_us  = 1'b1;
        step(1);

        // R4: a short dip restarts the count
        vds_over = 1'b1;
        step(25);
        vds_over = 1'b0;
        step(1);
        vds_over = 1'b1;
        expect_in(30, SIG_GATE, 1, "R4 before expiry");
        expect_in(31, SIG_GATE, 0, "R4 declared");
        expect_in(31, SIG_FLAG, 1, "R10 flag set");
        step(31);
        vds_over = 1'b0;

        // R9: latch-off policy
        expect_in(200, SIG_GATE, 0, "R9 stays off");
        expect_in(200, SIG_FLAG, 1, "R10 flag held");
        step(200);
        clr_fault = 1'b1;
        expect_in(1, SIG_FLAG, 0, "R10 flag cleared");
        step(1);
        clr_fault = 1'b0;
        cmd_on = 1'b0;
        step(1);
        expect_in(1, SIG_GATE, 0, "R9 off command");
        step(1);
        cmd_on = 1'b1;
        expect_in(1, SIG_GATE, 1, "R9 restart on rising edge");
        step(2);

        // R6/R7: retry policy, overload persists through one retry
        reg_write(2'd2, 3'd1, -1, 0, "R6 retry on");
        vds_over = 1'b1;
        expect_in(31, SIG_GATE, 0, "R6 declared");
        expect_in(31 + 2999, SIG_GATE, 0, "R6 inhibit last cycle");
        expect_in(31 + 3000, SIG_GATE, 1, "R6 retried");
        expect_in(31 + 3000 + 30, SIG_GATE, 1, "R7 before redeclare");
        expect_in(31 + 3000 + 31, SIG_GATE, 0, "R7 redeclared");
        step(31 + 3000 + 31);
        vds_over = 1'b0;
        expect_in(2999, SIG_GATE, 0, "R7 second inhibit");
        expect_in(3000, SIG_GATE, 1, "R7 second retry");
        step(3002);

        // R8: off command during inhibit cancels the retry
        vds_over = 1'b1;
        expect_in(31, SIG_GATE, 0, "R8 declared");
        step(31);
        vds_over = 1'b0;
        step(500);
        cmd_on = 1'b0;
        step(1);
        cmd_on = 1'b1;
        expect_in(2600, SIG_GATE, 0, "R8 retry cancelled");
        step(2600);
        cmd_on = 1'b0;
        step(1);
        cmd_on = 1'b1;
        expect_in(1, SIG_GATE, 1, "R8 fresh turn-on");
        step(2);

        // R1: code 1 gives 60 ticks, R6 inhibit 6000
        reg_write(2'd1, 3'd1, SIG_TMR, 1, "R1 timer code 1");
        vds_over = 1'b1;
        expect_in(60, SIG_GATE, 1, "R1 60 tick window");
        expect_in(61, SIG_GATE, 0, "R1 declared at 60 ticks");
        step(61);
        vds_over = 1'b0;
        expect_in(5999, SIG_GATE, 0, "R6 inhibit 6000 end");
        expect_in(6000, SIG_GATE, 1, "R6 retry after 6000");
        step(6003);

        if (sb.size() != 0) begin
            mismatched += sb.size();
            compared   += sb.size();
            $display("FAIL pending: %0d unchecked items actual %0d expected 0",
                     sb.size(), sb.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule